// File: doc/BRIEF.md
# Register-Level Serial Configuration Port

This block is a slave serial port through which a host reads and writes a bank of control registers. Each register is 1 to 4 bytes wide. A transaction opens when the active-low chip select falls. The host first sends an instruction byte that names the direction and the register address. A data phase follows, and its length is always the full width of the addressed register. The port has no byte addressing and no auto-increment, so one transaction always moves exactly one whole register.

The serial clock, chip select and data pins are taken as inputs synchronous to the block clock. The block finds the serial clock edges by oversampling them. Two bits of the control register at address 0 set the port's mode at run time. The first selects the bit order, MSB-first or LSB-first. The second selects 3-wire operation, where one bidirectional data pin carries both directions, or 4-wire operation, where a separate output pin carries read data. The bidirectional pin is presented as separate input, output and output-enable signals so that a pad can be attached outside the block. Every register value is visible in parallel on a flat output bus.

Top module: `spi_cfg_port`

## Requirements
- R1: The instruction byte is decoded as follows: bit 7 = 1 means read and 0 means write; bits 4:0 are the register address; bits 6:5 have no effect on the transaction.
- R2: The data phase after the instruction byte is exactly 8*B bits long. For a register at address a < NUM_REGS, B = (a mod 4) + 1. For any other address, B = 1.
- R3: After reset, register 0 holds 0, which selects MSB-first order and 3-wire mode. Byte j of register k (k > 0) holds the value 16*k + j. Bits above a register's width always read as 0.
- R4: A write updates the whole register in a single clock cycle, right after the serial clock rising edge that carries its last data bit. The register value on the parallel outputs never changes at any other time.
- R5: A read returns the addressed register's full value. An address with no register reads as 0, and a write to such an address changes no register.
- R6: When register 0 bit 0 is 1, the instruction byte and the data are both sent least significant bit first. When it is 0, both are sent most significant bit first. A change takes effect from the transaction after the write that made it.
- R7: When register 0 bit 1 is 0 (3-wire mode), read data appears on sdio_o, and sdio_oe is 1 only during the data phase of a read. When the bit is 1 (4-wire mode), read data appears on sdo and sdio_oe stays 0. The output that is not in use is held at 0.
- R8: Input bits are captured on the rising edge of the serial clock. Each read data bit is launched on the falling edge that comes before the rising edge at which the host samples it.
- R9: If chip select goes high before the data phase completes, the transaction is aborted and no register changes. The next falling edge of chip select starts a new instruction byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; it oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| spi_sclk | input | 1 | Serial clock from the host; idles low |
| spi_cs_n | input | 1 | Active-low chip select that frames each transaction |
| sdio_i | input | 1 | Serial data input; in 3-wire mode, the receive side of the shared pin |
| sdio_o | output | 1 | Read data for the shared pin in 3-wire mode |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Read data output in 4-wire mode |
| cfg_regs | output | NUM_REGS*MAX_BYTES*8 | All registers side by side; register k occupies slice k |

## Verification
On every cycle, the assertions check that a register value changes only in the cycle after a serial clock rising edge with chip select low. They also check that the shared pin is enabled only while chip select is low and only in 3-wire mode, that the read data bit on it moves only after a falling edge, and that the two data outputs are never active together. Only the bench scenarios can show that the right bits arrive in the right order for each of the four mode combinations, that data lengths follow the register widths, and that reset values are correct. They also cover the cases where nothing may happen: reserved instruction bits, writes to absent addresses, and aborted transactions.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned INSTR_BITS   = 8;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned RW_BIT       = 7;
  localparam int unsigned CTRL_LSB_BIT = 0;
  localparam int unsigned CTRL_4W_BIT  = 1;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  // Byte count of the register at an address; absent addresses use one byte.
  function automatic int unsigned reg_bytes(input int unsigned addr,
                                            input int unsigned nregs,
                                            input int unsigned max_bytes);
    if (addr < nregs) return (addr % max_bytes) + 1;
    return 1;
  endfunction

  // Reset value: control register is zero, others carry {addr, byte index} per byte.
  function automatic logic [63:0] reg_reset(input int unsigned addr,
                                            input int unsigned nregs,
                                            input int unsigned max_bytes);
    logic [63:0] v;
    v = '0;
    if (addr != 0 && addr < nregs) begin
      for (int unsigned j = 0; j < reg_bytes(addr, nregs, max_bytes); j++) begin
        v[j*BYTE_W +: BYTE_W] = 8'(((addr % 16) * 16) + j);
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/spi_cfg_edge.sv
module spi_cfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned REG_W    = MAX_BYTES * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wr_data,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int unsigned     NB   = reg_bytes(g, NUM_REGS, MAX_BYTES);
    localparam logic [REG_W-1:0] MASK = REG_W'((64'd1 << (NB * BYTE_W)) - 64'd1);
    localparam logic [REG_W-1:0] RST  = REG_W'(reg_reset(g, NUM_REGS, MAX_BYTES));

    logic             hit;
    logic [REG_W-1:0] val_q;
    logic [REG_W-1:0] val_d;

    assign hit = wr_en && (addr == ADDR_W'(g));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST;
      else if (hit) val_q <= val_d;
    end

    assign regs_flat[g*REG_W +: REG_W] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = regs_flat[i*REG_W +: REG_W];
    end
  end

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned REG_W    = MAX_BYTES * BYTE_W,
  localparam int unsigned IDX_W    = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              lsb_first_i,
  input  logic              four_wire_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o
);

  phase_e            phase_q, phase_n;
  logic [IDX_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  last_q, last_n;
  logic [7:0]        ibuf_q, ibuf_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              is_rd_q, is_rd_n;
  logic [REG_W-1:0]  wbuf_q, wbuf_n;
  logic              out_q, out_n;
  logic              drive;

  function automatic logic [IDX_W-1:0] last_index(input logic [ADDR_W-1:0] a);
    return IDX_W'(reg_bytes(int'(a), NUM_REGS, MAX_BYTES) * BYTE_W - 1);
  endfunction

  always_comb begin
    logic [7:0]       ib;
    logic [REG_W-1:0] wb;
    logic [2:0]       iidx;
    logic [IDX_W-1:0] didx;

    phase_n  = phase_q;
    cnt_n    = cnt_q;
    last_n   = last_q;
    ibuf_n   = ibuf_q;
    addr_n   = addr_q;
    is_rd_n  = is_rd_q;
    wbuf_n   = wbuf_q;
    out_n    = out_q;
    wr_en_o  = 1'b0;

    ib   = ibuf_q;
    wb   = wbuf_q;
    iidx = lsb_first_i ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);
    didx = lsb_first_i ? cnt_q : (last_q - cnt_q);

    if (cs_n_i) begin
      phase_n = PH_INSTR;
      cnt_n   = '0;
    end else begin
      unique case (phase_q)
        PH_INSTR: begin
          if (sclk_rise_i) begin
            ib[iidx] = sdi_i;
            ibuf_n   = ib;
            if (cnt_q == IDX_W'(INSTR_BITS - 1)) begin
              addr_n  = ib[ADDR_W-1:0];
              is_rd_n = ib[RW_BIT];
              last_n  = last_index(ib[ADDR_W-1:0]);
              wbuf_n  = '0;
              out_n   = 1'b0;
              cnt_n   = '0;
              phase_n = PH_DATA;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (sclk_fall_i && is_rd_q) out_n = rd_data_i[didx];
          if (sclk_rise_i) begin
            if (!is_rd_q) begin
              wb[didx] = sdi_i;
              wbuf_n   = wb;
            end
            if (cnt_q == last_q) begin
              phase_n = PH_DONE;
              wr_en_o = !is_rd_q;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_n = PH_DONE;
        end
      endcase
    end
    wr_data_o = wb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      last_q  <= '0;
      ibuf_q  <= '0;
      addr_q  <= '0;
      is_rd_q <= 1'b0;
      wbuf_q  <= '0;
      out_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      last_q  <= last_n;
      ibuf_q  <= ibuf_n;
      addr_q  <= addr_n;
      is_rd_q <= is_rd_n;
      wbuf_q  <= wbuf_n;
      out_q   <= out_n;
    end
  end

  assign drive     = (phase_q == PH_DATA) && is_rd_q && !cs_n_i;
  assign sdio_oe_o = drive && !four_wire_i;
  assign sdio_o    = drive && !four_wire_i && out_q;
  assign sdo_o     = drive && four_wire_i && out_q;
  assign addr_o    = addr_q;

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned REG_W    = MAX_BYTES * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      sdio_i,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  output logic                      sdo,
  output logic [NUM_REGS*REG_W-1:0] cfg_regs
);

  logic              rst_meta;
  logic              rst_n_s;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              lsb_first;
  logic              four_wire;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [REG_W-1:0]  wr_data;
  logic [REG_W-1:0]  rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign lsb_first = cfg_regs[CTRL_LSB_BIT];
  assign four_wire = cfg_regs[CTRL_4W_BIT];

  spi_cfg_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .sclk_i (spi_sclk),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  spi_cfg_shifter #(
    .NUM_REGS  (NUM_REGS),
    .MAX_BYTES (MAX_BYTES)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cs_n_i      (spi_cs_n),
    .sdi_i       (sdio_i),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .lsb_first_i (lsb_first),
    .four_wire_i (four_wire),
    .rd_data_i   (rd_data),
    .addr_o      (addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe),
    .sdo_o       (sdo)
  );

  spi_cfg_regbank #(
    .NUM_REGS  (NUM_REGS),
    .MAX_BYTES (MAX_BYTES)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs)
  );

endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
  parameter int unsigned CFG_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             four_wire,
  input logic             sdio_oe,
  input logic             sdio_o,
  input logic             sdo,
  input logic [CFG_W-1:0] cfg
);

  // R4: register contents move only right after a serial rising edge inside a frame
  p_commit_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> ($past(sclk_rise) && !$past(cs_n)));

  // R7: shared pin enabled only inside a frame
  p_oe_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !cs_n);

  // R7: shared pin never enabled in 4-wire mode
  p_oe_three_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire |-> !sdio_oe);

  // R7: the two read outputs are never both active
  p_one_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo |-> (!sdio_oe && !sdio_o));

  // R8: a driven read bit changes only after a serial falling edge
  p_launch_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && (sdio_o != $past(sdio_o))) |-> $past(sclk_fall));

endmodule

bind spi_cfg_port spi_cfg_port_chk #(
  .CFG_W (NUM_REGS * MAX_BYTES * 8)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (spi_cs_n),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .four_wire (four_wire),
  .sdio_oe   (sdio_oe),
  .sdio_o    (sdio_o),
  .sdo       (sdo),
  .cfg       (cfg_regs)
);

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;

  localparam int NR = 8;
  localparam int RW = 32;

  logic           clk;
  logic           rst_n;
  logic           spi_sclk;
  logic           spi_cs_n;
  logic           sdio_i;
  logic           sdio_o;
  logic           sdio_oe;
  logic           sdo;
  logic [NR*RW-1:0] cfg_regs;

  int total;
  int bad;
  int oe_err;
  logic [31:0] model [NR];
  bit cur_lsb;
  bit cur_fw;

  spi_cfg_port #(.NUM_REGS(NR), .MAX_BYTES(4)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .sdio_i   (sdio_i),
    .sdio_o   (sdio_o),
    .sdio_oe  (sdio_oe),
    .sdo      (sdo),
    .cfg_regs (cfg_regs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int nbits(input int a);
    return (a < NR) ? ((a % 4) + 1) * 8 : 8;
  endfunction

  function automatic logic [31:0] wmask(input int a);
    int n;
    n = nbits(a);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] rstval(input int a);
    logic [31:0] v;
    v = '0;
    if (a != 0 && a < NR)
      for (int j = 0; j < nbits(a) / 8; j++) v[j*8 +: 8] = 8'(a * 16 + j);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [1:0] resv, input int addr,
                      input logic [31:0] wdata, input int stop_at,
                      output logic [31:0] rdata);
    logic [7:0] ins;
    int nb;
    ins   = {rd, resv, 5'(addr)};
    nb    = nbits(addr);
    rdata = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    clks(2);
    for (int i = 0; i < 8 + nb; i++) begin
      int pos;
      if (i == stop_at) break;
      if (i < 8) begin
        pos    = cur_lsb ? i : 7 - i;
        sdio_i = ins[pos];
      end else begin
        pos    = cur_lsb ? (i - 8) : (nb - 1 - (i - 8));
        sdio_i = wdata[pos];
      end
      clks(2);
      spi_sclk = 1'b1;
      if (rd && i >= 8) begin
        rdata[pos] = cur_fw ? sdo : sdio_o;
        if (sdio_oe !== !cur_fw) oe_err++;
      end else if (sdio_oe !== 1'b0) begin
        oe_err++;
      end
      clks(2);
      spi_sclk = 1'b0;
    end
    clks(2);
    spi_cs_n = 1'b1;
    clks(3);
    if (sdio_oe !== 1'b0 || sdo !== 1'b0) oe_err++;
  endtask

  task automatic do_write(input int addr, input logic [31:0] d, input logic [1:0] resv);
    logic [31:0] dummy;
    xfer(1'b0, resv, addr, d, -1, dummy);
    if (addr < NR) model[addr] = d & wmask(addr);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < NR; a++)
      chk(cfg_regs[a*RW +: RW] === model[a], req, cfg_regs[a*RW +: RW], model[a]);
  endtask

  task automatic read_check(input int addr, input string req);
    logic [31:0] r;
    logic [31:0] e;
    xfer(1'b1, 2'b00, addr, 32'h0, -1, r);
    e = (addr < NR) ? model[addr] : 32'h0;
    chk(r === e, req, r, e);
  endtask

  task automatic set_mode(input bit lsb, input bit fw);
    do_write(0, {24'h0, 6'b101001, fw, lsb}, 2'b00);
    cur_lsb = lsb;
    cur_fw  = fw;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    total    = 0;
    bad      = 0;
    oe_err   = 0;
    cur_lsb  = 1'b0;
    cur_fw   = 1'b0;
    rst_n    = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    sdio_i   = 1'b0;
    for (int a = 0; a < NR; a++) model[a] = rstval(a);
    clks(4);
    rst_n = 1'b1;
    clks(4);

    // R3: reset values and idle outputs
    check_all("R3 reset value");
    chk(sdio_oe === 1'b0, "R7 idle oe", 32'(sdio_oe), 32'h0);
    chk(sdo === 1'b0, "R7 idle sdo", 32'(sdo), 32'h0);

    // R3 R2 R5 R8: read every address in MSB-first 3-wire before any write
    for (int a = 0; a < 32; a++) read_check(a, "R3 R2 R5 R8 reset readback");

    // R6 R7 R4 R2: sweep all four modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[0], m[1]);
      check_all("R4 R6 mode write");
      for (int a = 1; a < NR; a++)
        do_write(a, 32'h9E37_79B1 * (a + 1) ^ (32'h5A5A_0000 >> m), 2'b00);
      check_all("R4 R2 whole register write");
      for (int a = 0; a < 32; a++) read_check(a, "R5 R6 R7 R8 mode readback");
    end

    // back to MSB-first, 3-wire (this write uses LSB-first, 4-wire format)
    set_mode(1'b0, 1'b0);
    check_all("R6 mode restore");

    // R5: write to an absent address is discarded and it reads zero
    xfer(1'b0, 2'b00, 20, 32'hFFFF_FFFF, -1, r);
    check_all("R5 absent write discarded");
    read_check(20, "R5 absent read zero");

    // R1: reserved instruction bits ignored on write and read
    do_write(6, 32'h00C0_FFEE, 2'b11);
    check_all("R1 reserved bits write");
    xfer(1'b1, 2'b10, 6, 32'h0, -1, r);
    chk(r === model[6], "R1 reserved bits read", r, model[6]);

    // R9: abort in data phase leaves register unchanged
    xfer(1'b0, 2'b00, 7, 32'h1234_5678, 8 + 10, r);
    check_all("R9 abort in data phase");
    // R9: abort in instruction phase, then a full read restarts cleanly
    xfer(1'b0, 2'b00, 3, 32'hFFFF_FFFF, 5, r);
    check_all("R9 abort in instruction phase");
    read_check(7, "R9 restart after abort");

    // R4: register 5 written with one pattern, then a second write
    do_write(5, 32'hFFFF_0001, 2'b00);
    check_all("R4 second write");

    // R7: oe and output-pin behaviour throughout all transfers
    chk(oe_err == 0, "R7 oe and pin usage", 32'(oe_err), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule